// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver with Parity Check

This block recovers character frames from an asynchronous serial line. Each frame is a low start bit, then the data bits with the least significant bit first, then one parity bit, then a high stop bit. The line runs at a fixed rate of `CLKS_PER_BIT` system clocks per bit. The raw input passes through a chain of flip-flops that protects against metastability. A falling edge on the synchronised line starts a frame. A bit-time counter then places one sample near the middle of every bit.

The controller is a state machine with one state per bit position. The default width of its state register is four bits. It checks that the start bit is still low at half a bit time. It builds the data word, compares the received parity bit with the parity computed over that word, and checks the stop bit. A good frame produces the word together with a one-cycle valid pulse. A frame with a parity mismatch or a low stop bit produces a one-cycle error pulse instead.

Top module: `uart_rx_os`

## Requirements
- R1: During and right after a synchronous active-high reset, `rx_valid_o` and `rx_error_o` are 0 and `rx_word_o` is all zeros.
- R2: The serial input passes through `SYNC_STAGES` (default 3) flip-flops before any decision uses it. A falling edge on the synchronised line, seen in idle, starts a frame. If the line is high again at the half-bit sample (`CLKS_PER_BIT/2` clocks after the frame starts), the frame is dropped with no pulse on either output.
- R3: For a correct frame, `rx_valid_o` is high for exactly one cycle, and `rx_word_o` at that cycle holds the data bits in arrival order, with the first data bit at bit 0.
- R4: With `ODD_PARITY=0`, the parity bit is expected to equal the XOR of all data bits. On a mismatch, `rx_error_o` pulses for one cycle at the end of the frame and `rx_valid_o` stays low.
- R5: With `ODD_PARITY=1`, the parity bit is expected to equal the inverted XOR of the data bits. On a mismatch, `rx_error_o` pulses and no valid pulse is produced.
- R6: A 0 sampled at the stop-bit position makes `rx_error_o` pulse for one cycle instead of `rx_valid_o`, even when the parity is correct.
- R7: `rx_word_o` changes only in the cycle in which `rx_valid_o` is high. An errored or dropped frame leaves the last good word in place.
- R8: The state codes are idle=0, start=1, data bit k=2+k, parity=`DATA_W`+2 and stop=`DATA_W`+3. The stop state always returns to idle, so a frame that starts directly after the previous stop bit is received.
- R9: Each bit is sampled `CLKS_PER_BIT` clocks after the previous sample. The valid pulse is first seen `SYNC_STAGES`+1+`CLKS_PER_BIT/2`+`CLKS_PER_BIT`*(`DATA_W`+2) clock edges after the clock edge that precedes the start-bit falling edge. With the defaults this is 88 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line_i | input | 1 | Asynchronous serial input, idle high |
| rx_word_o | output | DATA_W | Last correctly received data word |
| rx_valid_o | output | 1 | One-cycle pulse for a correct frame |
| rx_error_o | output | 1 | One-cycle pulse for a parity or stop-bit fault |

## Verification
The case that is hardest to reach from the ports is a start condition that has to be abandoned. The line must fall and then rise again before the half-bit sample point, and the check must show that nothing came out. The stimulus produces this with short low glitches of two and three clocks. It then confirms that both pulse counts and the held word are unchanged, and that a correct frame sent right afterwards still arrives with the exact expected latency. A frame whose start bit follows the stop bit with no idle gap is also sent, to exercise the return from the stop state to idle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Fixed state codes; data bit k uses code ST_DATA0 + k.
    localparam int unsigned ST_IDLE  = 0;
    localparam int unsigned ST_START = 1;
    localparam int unsigned ST_DATA0 = 2;

    function automatic int unsigned parity_state(input int unsigned data_w);
        return data_w + 2;
    endfunction

    function automatic int unsigned stop_state(input int unsigned data_w);
        return data_w + 3;
    endfunction

    function automatic int unsigned state_width(input int unsigned data_w);
        return $clog2(data_w + 4);
    endfunction

    // Expected parity bit for a zero-extended word.
    function automatic logic expected_parity(input logic [63:0] word, input bit odd);
        return (^word) ^ odd;
    endfunction

endpackage

// File: rtl/rx_sync_chain.sv
module rx_sync_chain #(
    parameter int unsigned STAGES    = 3,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= RESET_VAL;
                    else     stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= RESET_VAL;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int unsigned CLKS_PER_BIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    output logic half_hit_o,
    output logic full_hit_o
);
    localparam int unsigned CW   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int unsigned HALF = CLKS_PER_BIT / 2;
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign half_hit_o = (cnt_q == HALF_LAST);
    assign full_hit_o = (cnt_q == FULL_LAST);

    AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_LAST); // R9

    AST_TIMER_WRAPS: assert property (@(posedge clk) disable iff (rst)
        full_hit_o |-> clear_i); // R9
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter bit          ODD_PARITY = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              half_hit_i,
    input  logic              full_hit_i,
    output logic              clear_o,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o,
    output logic              error_o
);
    localparam int unsigned SW = state_width(DATA_W);
    localparam logic [SW-1:0] S_IDLE   = SW'(ST_IDLE);
    localparam logic [SW-1:0] S_START  = SW'(ST_START);
    localparam logic [SW-1:0] S_DATA0  = SW'(ST_DATA0);
    localparam logic [SW-1:0] S_PARITY = SW'(parity_state(DATA_W));
    localparam logic [SW-1:0] S_STOP   = SW'(stop_state(DATA_W));

    logic [SW-1:0]     state_q, state_d;
    logic              prev_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_ok_q;
    logic              in_data;
    logic              frame_good;

    assign in_data    = (state_q >= S_DATA0) && (state_q < S_PARITY);
    assign frame_good = rx_i && par_ok_q;

    always_comb begin
        state_d = state_q;
        clear_o = 1'b0;
        if (state_q == S_IDLE) begin
            clear_o = 1'b1;
            if (prev_q && !rx_i) state_d = S_START;
        end else if (state_q == S_START) begin
            if (half_hit_i) begin
                clear_o = 1'b1;
                state_d = rx_i ? S_IDLE : S_DATA0;
            end
        end else if (state_q <= S_PARITY) begin
            if (full_hit_i) begin
                clear_o = 1'b1;
                state_d = state_q + 1'b1;
            end
        end else begin
            if (full_hit_i) begin
                clear_o = 1'b1;
                state_d = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            prev_q   <= 1'b1;
            shift_q  <= '0;
            par_ok_q <= 1'b0;
            word_o   <= '0;
            valid_o  <= 1'b0;
            error_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= rx_i;
            valid_o <= 1'b0;
            error_o <= 1'b0;
            if (in_data && full_hit_i)
                shift_q <= {rx_i, shift_q[DATA_W-1:1]};
            if ((state_q == S_PARITY) && full_hit_i)
                par_ok_q <= (rx_i == expected_parity(64'(shift_q), ODD_PARITY));
            if ((state_q == S_STOP) && full_hit_i) begin
                valid_o <= frame_good;
                error_o <= !frame_good;
                if (frame_good) word_o <= shift_q;
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R3

    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && error_o)); // R4

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (valid_o || $stable(word_o))); // R7

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_q <= S_STOP); // R8

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_STOP && full_hit_i) |=> (state_q == S_IDLE)); // R8

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_START && $past(state_q) != S_START) |-> $past(state_q) == S_IDLE); // R2

    AST_PULSE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        (valid_o || error_o) |-> $past(state_q) == S_STOP); // R6
endmodule

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned CLKS_PER_BIT = 8,
    parameter int unsigned SYNC_STAGES  = 3,
    parameter bit          ODD_PARITY   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line_i,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              rx_error_o
);
    logic rx_sync;
    logic tmr_clear;
    logic half_hit;
    logic full_hit;

    rx_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line_i),
        .dout (rx_sync)
    );

    rx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (tmr_clear),
        .half_hit_o (half_hit),
        .full_hit_o (full_hit)
    );

    rx_frame_fsm #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .rx_i       (rx_sync),
        .half_hit_i (half_hit),
        .full_hit_i (full_hit),
        .clear_o    (tmr_clear),
        .word_o     (rx_word_o),
        .valid_o    (rx_valid_o),
        .error_o    (rx_error_o)
    );
endmodule

// File: tb/uart_rx_os_tb_top.sv
module uart_rx_os_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int CPB  = 8;
    localparam int SYNC = 3;
    localparam int LAT  = SYNC + 1 + CPB / 2 + CPB * (DW + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_e = 1'b1;
    logic line_o = 1'b1;
    logic [DW-1:0] word_e, word_o;
    logic valid_e, valid_o, err_e, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cyc = 0;
    int t0 = 0;
    int vcnt_e = 0, vcnt_o = 0, ecnt_e = 0, ecnt_o = 0;
    int lat_e = 0, lat_o = 0;
    bit pv_e = 1'b0, pv_o = 1'b0, pe_e = 1'b0, pe_o = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_os #(.DATA_W(DW), .CLKS_PER_BIT(CPB), .SYNC_STAGES(SYNC), .ODD_PARITY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .rx_line_i(line_e),
        .rx_word_o(word_e), .rx_valid_o(valid_e), .rx_error_o(err_e));

    uart_rx_os #(.DATA_W(DW), .CLKS_PER_BIT(CPB), .SYNC_STAGES(SYNC), .ODD_PARITY(1'b1)) dut_odd_i (
        .clk(clk), .rst(rst), .rx_line_i(line_o),
        .rx_word_o(word_o), .rx_valid_o(valid_o), .rx_error_o(err_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_e) begin vcnt_e++; lat_e = cyc - t0; end
            if (valid_o) begin vcnt_o++; lat_o = cyc - t0; end
            if (err_e) ecnt_e++;
            if (err_o) ecnt_o++;
            if (valid_e && pv_e) chk(1'b0, "R3 even valid width", 2, 1);
            if (valid_o && pv_o) chk(1'b0, "R3 odd valid width", 2, 1);
            if (err_e && pe_e) chk(1'b0, "R4 even error width", 2, 1);
            if (err_o && pe_o) chk(1'b0, "R5 odd error width", 2, 1);
            pv_e = valid_e; pv_o = valid_o; pe_e = err_e; pe_o = err_o;
        end
    end

    task automatic drive_bit(input logic be, input logic bo);
        line_e = be;
        line_o = bo;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic send_frame(input logic [DW-1:0] d, input bit bad_par,
                              input bit bad_stop, input int gap);
        logic pe, po;
        pe = (^d) ^ bad_par;
        po = ~(^d) ^ bad_par;
        t0 = cyc;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < DW; i++) drive_bit(d[i], d[i]);
        drive_bit(pe, po);
        drive_bit(!bad_stop, !bad_stop);
        line_e = 1'b1;
        line_o = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic good_frame(input logic [DW-1:0] d);
        int ve, vo, ee, eo;
        ve = vcnt_e; vo = vcnt_o; ee = ecnt_e; eo = ecnt_o;
        send_frame(d, 1'b0, 1'b0, 4);
        chk(vcnt_e == ve + 1, "R3 even valid count", vcnt_e - ve, 1);
        chk(vcnt_o == vo + 1, "R5 odd valid count", vcnt_o - vo, 1);
        chk(ecnt_e == ee && ecnt_o == eo, "R4 no error on good frame", ecnt_e + ecnt_o - ee - eo, 0);
        chk(word_e == d, "R3 even word LSB first", int'(word_e), int'(d));
        chk(word_o == d, "R5 odd word", int'(word_o), int'(d));
        chk(lat_e == LAT, "R9 even latency", lat_e, LAT);
        chk(lat_o == LAT, "R9 odd latency", lat_o, LAT);
    endtask

    task automatic bad_frame(input logic [DW-1:0] d, input bit bad_par, input bit bad_stop,
                             input logic [DW-1:0] held, input string req);
        int ve, vo, ee, eo;
        ve = vcnt_e; vo = vcnt_o; ee = ecnt_e; eo = ecnt_o;
        send_frame(d, bad_par, bad_stop, 4);
        chk(vcnt_e == ve && vcnt_o == vo, req, vcnt_e + vcnt_o - ve - vo, 0);
        chk(ecnt_e == ee + 1, req, ecnt_e - ee, 1);
        chk(ecnt_o == eo + 1, req, ecnt_o - eo, 1);
        chk(word_e == held && word_o == held, "R7 word held after error", int'(word_e), int'(held));
    endtask

    task automatic glitch(input int low_clks, input logic [DW-1:0] held);
        int ve, ee;
        ve = vcnt_e + vcnt_o; ee = ecnt_e + ecnt_o;
        line_e = 1'b0; line_o = 1'b0;
        repeat (low_clks) @(negedge clk);
        line_e = 1'b1; line_o = 1'b1;
        repeat (3 * CPB) @(negedge clk);
        chk(vcnt_e + vcnt_o == ve, "R2 glitch gives no valid", vcnt_e + vcnt_o - ve, 0);
        chk(ecnt_e + ecnt_o == ee, "R2 glitch gives no error", ecnt_e + ecnt_o - ee, 0);
        chk(word_e == held, "R7 word kept after glitch", int'(word_e), int'(held));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(valid_e == 1'b0 && err_e == 1'b0, "R1 outputs low in reset", {valid_e, err_e}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(word_e == '0 && word_o == '0, "R1 word zero after reset", int'(word_e), 0);
        chk(!valid_e && !valid_o && !err_e && !err_o, "R1 pulses low after reset",
            {valid_e, valid_o, err_e, err_o}, 0);
        repeat (4) @(negedge clk);

        // Full sweep of data words on both parity settings
        for (int v = 0; v < (1 << DW); v++) good_frame(DW'(v));

        // Parity faults
        good_frame(8'hA5);
        bad_frame(8'h3C, 1'b1, 1'b0, 8'hA5, "R4 even parity mismatch");
        bad_frame(8'h01, 1'b1, 1'b0, 8'hA5, "R5 odd parity mismatch");
        // Stop-bit fault with correct parity
        bad_frame(8'h7E, 1'b0, 1'b1, 8'hA5, "R6 low stop bit");

        // Start glitches abandoned at the half-bit sample
        glitch(2, 8'hA5);
        glitch(3, 8'hA5);
        good_frame(8'h5A);

        // Back-to-back frames: no idle between stop and next start
        begin
            int ve;
            ve = vcnt_e;
            send_frame(8'hC3, 1'b0, 1'b0, 0);
            send_frame(8'h96, 1'b0, 1'b0, 4);
            chk(vcnt_e == ve + 2, "R8 back-to-back frames both received", vcnt_e - ve, 2);
            chk(word_e == 8'h96, "R8 second frame word", int'(word_e), 8'h96);
            chk(lat_e == LAT, "R9 latency of second frame", lat_e, LAT);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule